// File: doc/BRIEF.md
# Card Link Selector with Answer-to-Reset Sender

This block settles, once per power cycle, which of two link styles a secure-memory device uses on its shared pins: a synchronous two-wire serial link, or the asynchronous ISO 7816-3 T=0 character link used by smart card readers. The reset pin has an internal pull-up, so a pin left unconnected reads high and gives the synchronous link. A pin held low by a reader at the first card clock gives the asynchronous link. The choice holds until the power-on reset is applied again.

In the asynchronous case the block waits a fixed number of card clocks after each rising edge of the reset pin. It then sends the 64-bit answer-to-reset value as eight framed characters on the open-drain I/O line. A bit lasts one elementary time unit of `ETU_CLKS` card clocks. The card clock and reset pins are asynchronous to the system clock, so they are resynchronised and all timing counts rising edges of the card clock. In the synchronous case the I/O line is never driven. A ready flag tells the two-wire command logic that the required warm-up clock pulses have arrived.

Top module: `card_link_select`

## Requirements
- R1: While and after the power-on reset `rst`, before any card clock rising edge, `mode_valid`, `mode_async`, `sync_ready`, `io_drive_low` and `atr_done` are all 0.
- R2: If `rst_pin` is high at the first card clock rising edge after power-on reset, the block selects the synchronous link: `mode_valid` becomes 1 and `mode_async` stays 0. No selection is made before that edge.
- R3: If `rst_pin` is low at the first card clock rising edge after power-on reset, the block selects the asynchronous link: `mode_valid` and `mode_async` both become 1.
- R4: Once made, the selection does not change when `rst_pin` toggles. Only a new power-on reset clears it, and the next selection then follows R2 or R3 again.
- R5: `sync_ready` rises only in synchronous mode, after `SYNC_PULSES` card clock rising edges counted from and including the selecting edge. It stays 0 in asynchronous mode.
- R6: In synchronous mode `io_drive_low` and `atr_done` stay 0, whatever `rst_pin` does.
- R7: In asynchronous mode, after a rising edge of `rst_pin`, the I/O line stays released (`io_drive_low` = 0) for `COLD_CLKS`-1 card clock rising edges. The start bit begins at edge number `COLD_CLKS`.
- R8: Every transmitted bit lasts exactly `ETU_CLKS` card clock rising edges.
- R9: Each character is one start bit (line low, `io_drive_low` = 1), eight data bits, one even-parity bit (the XOR of the data bits), then `GUARD_ETUS` bit times with the line released. `io_drive_low` = 1 exactly when the line level is 0.
- R10: Data bits go least significant first. Character k carries `atr_data[8k+7:8k]`, and the characters are sent for k = 0 up to `ATR_BYTES`-1.
- R11: `atr_done` rises on the card clock edge that ends the last guard time of the last character. It then stays 1 with the line released until `rst_pin` falls or power-on reset is applied.
- R12: A falling edge of `rst_pin` in asynchronous mode stops any character in progress, releases the line and clears `atr_done`. The next rising edge of `rst_pin` restarts the full sequence from the wait of R7 and character 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| rst_pin | input | 1 | Reset pin level (pulled up when unconnected), asynchronous |
| card_clk_pin | input | 1 | Card clock pin level, asynchronous |
| atr_data | input | 8*ATR_BYTES | Answer-to-reset value, byte k at bits 8k+7:8k |
| mode_valid | output | 1 | A link style has been selected |
| mode_async | output | 1 | Selected link is the asynchronous one |
| sync_ready | output | 1 | Synchronous warm-up pulses received |
| io_drive_low | output | 1 | Pull the open-drain I/O line low |
| atr_done | output | 1 | Answer-to-reset fully sent |

## Verification
The selection is tried with the reset pin high and then low at the first card clock, with power-on resets in between. This shows whether the sampled level, and not some later edge, decides the link, and whether a fresh power-on reset can reselect it. The reset pin is also toggled after the selection in both modes, which catches a latch that reopens, and in synchronous mode any drive of the line. The answer-to-reset is checked at the first and the last card clock of every bit, using values with distinct bytes, odd and even parity and a zero low bit. This catches errors in bit length, bit order, byte order, parity sense and the cold-reset wait. An abort in the middle of a driven zero bit, then a restart, shows whether state from the broken attempt leaks into the next one.

// File: rtl/card_link_pkg.sv
package card_link_pkg;

  typedef enum logic [1:0] {
    LINK_NONE  = 2'd0,
    LINK_SYNC  = 2'd1,
    LINK_ASYNC = 2'd2
  } link_mode_e;

  function automatic logic even_parity(input logic [7:0] data);
    return ^data;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] prev_o
);

  // One synchroniser chain per pin; the extra stage keeps the previous level
  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
      if (rst) chain_q <= {(STAGES+1){RST_VAL[g]}};
      else     chain_q <= {chain_q[STAGES-1:0], pins_i[g]};
    end

    assign level_o[g] = chain_q[STAGES-1];
    assign prev_o[g]  = chain_q[STAGES];
  end

endmodule

// File: rtl/link_mode_latch.sv
module link_mode_latch
  import card_link_pkg::*;
#(
  parameter int SYNC_PULSES = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       card_rise_i,
  input  logic       rst_level_i,
  output link_mode_e mode_o,
  output logic       sync_ready_o
);

  localparam int PW = $clog2(SYNC_PULSES + 1);

  link_mode_e    mode_q;
  logic [PW-1:0] pulse_q;
  logic          ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= LINK_NONE;
      pulse_q <= '0;
      ready_q <= 1'b0;
    end else begin
      if (card_rise_i) begin
        case (mode_q)
          LINK_NONE: begin
            mode_q  <= rst_level_i ? LINK_SYNC : LINK_ASYNC;
            pulse_q <= rst_level_i ? PW'(1) : '0;
          end
          LINK_SYNC: begin
            if (pulse_q != PW'(SYNC_PULSES)) pulse_q <= pulse_q + PW'(1);
          end
          default: ;
        endcase
      end
      ready_q <= (mode_q == LINK_SYNC) && (pulse_q == PW'(SYNC_PULSES));
    end
  end

  assign mode_o       = mode_q;
  assign sync_ready_o = ready_q;

  p_mode_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q != LINK_NONE) |=> (mode_q == $past(mode_q)));

  p_select_on_edge_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LINK_NONE && !card_rise_i) |=> (mode_q == LINK_NONE));

  p_ready_sync_only_r5: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> (mode_q == LINK_SYNC));

endmodule

// File: rtl/cold_reset_timer.sv
module cold_reset_timer #(
  parameter int COLD_CLKS = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  input  logic card_rise_i,
  input  logic rst_rise_i,
  input  logic rst_fall_i,
  output logic start_o,
  output logic abort_o
);

  localparam int CW = $clog2(COLD_CLKS + 1);

  logic          counting_q;
  logic [CW-1:0] cnt_q;
  logic          start_q;
  logic          abort_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      counting_q <= 1'b0;
      cnt_q      <= '0;
      start_q    <= 1'b0;
      abort_q    <= 1'b0;
    end else begin
      start_q <= 1'b0;
      abort_q <= 1'b0;
      if (!async_i) begin
        counting_q <= 1'b0;
        cnt_q      <= '0;
      end else if (rst_fall_i) begin
        counting_q <= 1'b0;
        cnt_q      <= '0;
        abort_q    <= 1'b1;
      end else if (rst_rise_i) begin
        counting_q <= 1'b1;
        cnt_q      <= '0;
      end else if (counting_q && card_rise_i) begin
        if (cnt_q == CW'(COLD_CLKS - 1)) begin
          counting_q <= 1'b0;
          cnt_q      <= '0;
          start_q    <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign start_o = start_q;
  assign abort_o = abort_q;

  p_start_async_r7: assert property (@(posedge clk) disable iff (rst)
    start_q |-> async_i);

  p_start_abort_excl_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_q, abort_q}));

endmodule

// File: rtl/atr_serializer.sv
module atr_serializer
  import card_link_pkg::*;
#(
  parameter int ATR_BYTES  = 8,
  parameter int ETU_CLKS   = 372,
  parameter int GUARD_ETUS = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   card_rise_i,
  input  logic                   start_i,
  input  logic                   abort_i,
  input  logic [ATR_BYTES*8-1:0] atr_i,
  output logic                   drive_low_o,
  output logic                   done_o
);

  localparam int CHAR_BITS = 10 + GUARD_ETUS;
  localparam int BIW       = $clog2(CHAR_BITS);
  localparam int BYW       = (ATR_BYTES > 1) ? $clog2(ATR_BYTES) : 1;
  localparam int EW        = (ETU_CLKS > 1) ? $clog2(ETU_CLKS) : 1;

  logic           active_q;
  logic           done_q;
  logic           drive_q;
  logic [BYW-1:0] byte_q;
  logic [BIW-1:0] bit_q;
  logic [EW-1:0]  etu_q;

  logic [7:0] cur_byte;
  logic       level;
  logic       etu_end;
  logic       last_bit;
  logic       last_byte;

  // Line level of the current bit slot: start, data LSB first, parity, guard
  always_comb begin
    cur_byte = atr_i[int'(byte_q)*8 +: 8];
    if (bit_q == '0)             level = 1'b0;
    else if (bit_q <= BIW'(8))   level = cur_byte[3'(bit_q - BIW'(1))];
    else if (bit_q == BIW'(9))   level = even_parity(cur_byte);
    else                         level = 1'b1;
  end

  assign etu_end   = (etu_q == EW'(ETU_CLKS - 1));
  assign last_bit  = (bit_q == BIW'(CHAR_BITS - 1));
  assign last_byte = (byte_q == BYW'(ATR_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      drive_q  <= 1'b0;
      byte_q   <= '0;
      bit_q    <= '0;
      etu_q    <= '0;
    end else begin
      drive_q <= active_q & ~level;
      if (abort_i) begin
        active_q <= 1'b0;
        done_q   <= 1'b0;
        byte_q   <= '0;
        bit_q    <= '0;
        etu_q    <= '0;
      end else if (start_i) begin
        active_q <= 1'b1;
        done_q   <= 1'b0;
        byte_q   <= '0;
        bit_q    <= '0;
        etu_q    <= '0;
      end else if (active_q && card_rise_i) begin
        if (etu_end) begin
          etu_q <= '0;
          if (last_bit) begin
            bit_q <= '0;
            if (last_byte) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end else begin
              byte_q <= byte_q + BYW'(1);
            end
          end else begin
            bit_q <= bit_q + BIW'(1);
          end
        end else begin
          etu_q <= etu_q + EW'(1);
        end
      end
    end
  end

  assign drive_low_o = drive_q;
  assign done_o      = done_q;

  p_done_or_busy_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({active_q, done_q}));

  p_done_released_r11: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !drive_q);

  p_abort_clears_r12: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (!active_q && !done_q));

  p_start_bit_low_r9: assert property (@(posedge clk) disable iff (rst)
    (start_i && !abort_i) |=> ##1 drive_q);

endmodule

// File: rtl/card_link_select.sv
module card_link_select
  import card_link_pkg::*;
#(
  parameter int ETU_CLKS    = 372,
  parameter int COLD_CLKS   = 400,
  parameter int SYNC_PULSES = 5,
  parameter int ATR_BYTES   = 8,
  parameter int GUARD_ETUS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rst_pin,
  input  logic                   card_clk_pin,
  input  logic [ATR_BYTES*8-1:0] atr_data,
  output logic                   mode_valid,
  output logic                   mode_async,
  output logic                   sync_ready,
  output logic                   io_drive_low,
  output logic                   atr_done
);

  localparam int PIN_CLK = 0;
  localparam int PIN_RST = 1;

  logic [1:0] pin_level;
  logic [1:0] pin_prev;
  logic       card_rise;
  logic       rst_rise;
  logic       rst_fall;
  link_mode_e mode;
  logic       cold_start;
  logic       cold_abort;

  // Reset pin resets high (pull-up), card clock resets low
  pin_sync #(
    .WIDTH   (2),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (2'b10)
  ) u_pins (
    .clk     (clk),
    .rst     (rst),
    .pins_i  ({rst_pin, card_clk_pin}),
    .level_o (pin_level),
    .prev_o  (pin_prev)
  );

  assign card_rise = pin_level[PIN_CLK] & ~pin_prev[PIN_CLK];
  assign rst_rise  = pin_level[PIN_RST] & ~pin_prev[PIN_RST];
  assign rst_fall  = ~pin_level[PIN_RST] & pin_prev[PIN_RST];

  link_mode_latch #(
    .SYNC_PULSES (SYNC_PULSES)
  ) u_mode (
    .clk          (clk),
    .rst          (rst),
    .card_rise_i  (card_rise),
    .rst_level_i  (pin_level[PIN_RST]),
    .mode_o       (mode),
    .sync_ready_o (sync_ready)
  );

  cold_reset_timer #(
    .COLD_CLKS (COLD_CLKS)
  ) u_cold (
    .clk         (clk),
    .rst         (rst),
    .async_i     (mode == LINK_ASYNC),
    .card_rise_i (card_rise),
    .rst_rise_i  (rst_rise),
    .rst_fall_i  (rst_fall),
    .start_o     (cold_start),
    .abort_o     (cold_abort)
  );

  atr_serializer #(
    .ATR_BYTES  (ATR_BYTES),
    .ETU_CLKS   (ETU_CLKS),
    .GUARD_ETUS (GUARD_ETUS)
  ) u_atr (
    .clk         (clk),
    .rst         (rst),
    .card_rise_i (card_rise),
    .start_i     (cold_start),
    .abort_i     (cold_abort),
    .atr_i       (atr_data),
    .drive_low_o (io_drive_low),
    .done_o      (atr_done)
  );

  assign mode_valid = (mode != LINK_NONE);
  assign mode_async = (mode == LINK_ASYNC);

  p_sync_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == LINK_SYNC) |-> (!io_drive_low && !atr_done));

  p_no_drive_unselected_r1: assert property (@(posedge clk) disable iff (rst)
    !mode_valid |-> (!io_drive_low && !atr_done && !sync_ready));

endmodule

// File: tb/card_link_select_bench.sv
module card_link_select_bench;

  localparam int ETU   = 16;
  localparam int COLD  = 40;
  localparam int PULSE = 5;
  localparam int NB    = 8;
  localparam int GUARD = 2;
  localparam int CHARB = 10 + GUARD;

  logic          clk = 1'b0;
  logic          rst;
  logic          rst_pin;
  logic          card_clk;
  logic [NB*8-1:0] atr;
  logic          mode_valid, mode_async, sync_ready, io_drive_low, atr_done;

  int checks = 0;
  int errors = 0;
  int low_cycles = 0;

  always #4 clk = ~clk;

  always @(posedge clk) if (io_drive_low) low_cycles <= low_cycles + 1;

  card_link_select #(
    .ETU_CLKS    (ETU),
    .COLD_CLKS   (COLD),
    .SYNC_PULSES (PULSE),
    .ATR_BYTES   (NB),
    .GUARD_ETUS  (GUARD),
    .SYNC_STAGES (2)
  ) u_card_link_select (
    .clk          (clk),
    .rst          (rst),
    .rst_pin      (rst_pin),
    .card_clk_pin (card_clk),
    .atr_data     (atr),
    .mode_valid   (mode_valid),
    .mode_async   (mode_async),
    .sync_ready   (sync_ready),
    .io_drive_low (io_drive_low),
    .atr_done     (atr_done)
  );

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic card_edges(input int n);
    for (int i = 0; i < n; i++) begin
      card_clk = 1'b1;
      repeat (3) @(negedge clk);
      card_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic power_up(input logic pin);
    @(negedge clk);
    rst      = 1'b1;
    rst_pin  = pin;
    card_clk = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic int exp_drive(input logic [NB*8-1:0] v, input int b, input int k);
    logic [7:0] d;
    d = v[b*8 +: 8];
    if (k == 0) return 1;
    if (k <= 8) return d[k-1] ? 0 : 1;
    if (k == 9) return (^d) ? 0 : 1;
    return 0;
  endfunction

  // Called right after rst_pin has risen, before any further card edge
  task automatic check_atr(input logic [NB*8-1:0] v);
    string req;
    card_edges(COLD - 1);
    chk(io_drive_low, 0, "R7", "line released before cold wait ends");
    chk(atr_done, 0, "R11", "done low during cold wait");
    card_edges(1);
    for (int b = 0; b < NB; b++) begin
      for (int k = 0; k < CHARB; k++) begin
        req = (k >= 1 && k <= 8) ? "R10" : "R9";
        chk(io_drive_low, exp_drive(v, b, k), req, $sformatf("byte %0d bit %0d first clock", b, k));
        card_edges(ETU - 1);
        chk(io_drive_low, exp_drive(v, b, k), "R8", $sformatf("byte %0d bit %0d last clock", b, k));
        if (b == NB - 1 && k == CHARB - 1) chk(atr_done, 0, "R11", "done low before final edge");
        card_edges(1);
      end
    end
    chk(atr_done, 1, "R11", "done after last guard time");
    chk(io_drive_low, 0, "R11", "line released after sequence");
  endtask

  task automatic t_reset_state();
    power_up(1'b1);
    chk(mode_valid, 0, "R1", "mode_valid after reset");
    chk(mode_async, 0, "R1", "mode_async after reset");
    chk(sync_ready, 0, "R1", "sync_ready after reset");
    chk(io_drive_low, 0, "R1", "io_drive_low after reset");
    chk(atr_done, 0, "R1", "atr_done after reset");
    repeat (20) @(negedge clk);
    chk(mode_valid, 0, "R2", "no selection without card clock");
  endtask

  task automatic t_sync_mode();
    int base;
    power_up(1'b1);
    base = low_cycles;
    card_edges(1);
    chk(mode_valid, 1, "R2", "selected on first edge");
    chk(mode_async, 0, "R2", "synchronous chosen with pin high");
    card_edges(PULSE - 2);
    chk(sync_ready, 0, "R5", "not ready one pulse early");
    card_edges(1);
    chk(sync_ready, 1, "R5", "ready after warm-up pulses");
    rst_pin = 1'b0;
    card_edges(3);
    rst_pin = 1'b1;
    card_edges(COLD + 2 * CHARB * ETU);
    chk(mode_async, 0, "R4", "sync mode kept after pin toggle");
    chk(mode_valid, 1, "R4", "selection kept after pin toggle");
    chk(low_cycles - base, 0, "R6", "line never driven in sync mode");
    chk(atr_done, 0, "R6", "no done flag in sync mode");
  endtask

  task automatic t_async_atr();
    power_up(1'b0);
    card_edges(3);
    chk(mode_valid, 1, "R3", "selected on first edge");
    chk(mode_async, 1, "R3", "asynchronous chosen with pin low");
    chk(sync_ready, 0, "R5", "never ready in async mode");
    chk(io_drive_low, 0, "R7", "line released before reset pin rises");
    atr = 64'h3B_A5_0F_C3_96_00_FF_01;
    rst_pin = 1'b1;
    repeat (3) @(negedge clk);
    check_atr(atr);
    card_edges(3 * ETU);
    chk(atr_done, 1, "R11", "done held after sequence");
    chk(io_drive_low, 0, "R11", "line stays released");
  endtask

  task automatic t_abort_restart();
    rst_pin = 1'b0;
    repeat (6) @(negedge clk);
    chk(atr_done, 0, "R12", "done cleared by falling pin");
    chk(mode_async, 1, "R4", "async mode kept after pin fall");
    atr = 64'h5A_C4_81_7E_22_10_E3_3B;
    card_edges(2);
    rst_pin = 1'b1;
    repeat (3) @(negedge clk);
    card_edges(COLD + 3 * ETU + ETU / 2);
    chk(io_drive_low, 1, "R12", "zero bit driven before abort");
    rst_pin = 1'b0;
    repeat (6) @(negedge clk);
    chk(io_drive_low, 0, "R12", "line released by abort");
    chk(atr_done, 0, "R12", "no done after abort");
    card_edges(2 * ETU);
    chk(io_drive_low, 0, "R12", "line stays released while pin low");
    rst_pin = 1'b1;
    repeat (3) @(negedge clk);
    check_atr(atr);
  endtask

  task automatic t_power_cycle();
    power_up(1'b1);
    chk(mode_valid, 0, "R4", "power-on reset clears selection");
    card_edges(1);
    chk(mode_async, 0, "R4", "new power cycle selects sync");
    chk(mode_valid, 1, "R4", "new power cycle selected");
  endtask

  initial begin
    rst      = 1'b1;
    rst_pin  = 1'b1;
    card_clk = 1'b0;
    atr      = '0;
    t_reset_state();
    t_sync_mode();
    t_async_atr();
    t_abort_restart();
    t_power_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=%0d expected=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule